// File: doc/BRIEF.md
# UART transmit-empty interrupt generator

This block decides when a UART with a transmit FIFO raises its "transmit holding register empty" request. It watches the FIFO's empty flag and occupancy, the software strobes that write the holding register and read the interrupt identification register, and a per-bit baud tick. Its single output tells the interrupt priority logic that a transmit-empty request is pending.

The request does not always fire the moment the FIFO drains. If the FIFO has held at least two characters at one time since the last empty event, the request fires at once. If it has not, the request is held back for one character time without the stop bit. The same applies at start-up. This gives software time to top the FIFO up without taking an interrupt for every single character.

A write to the holding register always withdraws the request. A read of the identification register withdraws it only when this source is the highest pending one at the time of the read.

Top module: `uart_txe_irq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `thre_pend` is 0, and no countdown is running.
- R2: In the cycle after any cycle in which `fifo_empty` is 0, `thre_pend` is 0.
- R3: An empty event is a cycle in which `fifo_empty` is 1 and was 0 in the previous cycle (or this is the first cycle after reset). If the FIFO has held two or more characters since the last empty event, `thre_pend` is 1 in the cycle after the empty event, unless a clearing strobe is present in that same cycle.
- R4: If the FIFO has not held two characters since the last empty event, `thre_pend` stays 0 after the empty event while the delay runs. This includes the empty state that follows reset.
- R5: The delay lasts N baud ticks, with N = 1 + (5 + `word_sel`) + `parity_en`. `word_sel` 0, 1, 2 and 3 mean 5, 6, 7 and 8 data bits. Only ticks after the empty-event cycle are counted. `thre_pend` becomes 1 in the cycle after the Nth tick.
- R6: A cycle with `thr_wr` = 1 makes `thre_pend` 0 in the following cycle.
- R7: A cycle with `iir_rd` = 1 and `thre_top` = 1 makes `thre_pend` 0 in the following cycle. The request does not fire again until the next empty event.
- R8: A cycle with `iir_rd` = 1 and `thre_top` = 0 leaves a pending `thre_pend` at 1.
- R9: A `thr_wr` during the delay cancels it. No request follows from that empty event, however many ticks arrive afterwards.
- R10: The "held two characters" record is cleared at each empty event. A later event that follows a single-character fill is therefore delayed.
- R11: Occupancy that reaches 2 even briefly is remembered until the next empty event, even if it falls back to 1 before the FIFO drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_empty | input | 1 | Transmit FIFO empty flag |
| fifo_level | input | LVL_W (5) | Current transmit FIFO occupancy |
| thr_wr | input | 1 | One-cycle strobe for a holding-register write |
| iir_rd | input | 1 | One-cycle strobe for an identification-register read |
| thre_top | input | 1 | Transmit-empty is the highest pending interrupt source |
| baud_tick | input | 1 | One pulse per transmitted bit time |
| word_sel | input | SEL_W (2) | Data bits minus DATA_MIN |
| parity_en | input | 1 | Parity bit is enabled |
| thre_pend | output | 1 | Transmit-empty request pending |

## Verification
The bench builds the block with its defaults: a 16-deep FIFO, a minimum of 5 data bits and a 2-bit length select. These values allow the shortest delay (6 ticks, 5 bits without parity) and the longest delay (10 ticks, 8 bits with parity) to be reached, and the occupancy field is wide enough for the two-character threshold. A behavioural model runs beside the design and predicts the request in every cycle. The stimulus covers the start-up hold-back, the prompt firing after a two-character fill, a fill that drops back to one character before draining, a write that cancels a running delay, and both forms of the identification read.

// File: rtl/thre_pkg.sv
package thre_pkg;

   // Bit times counted before the empty request: start + data + optional parity.
   function automatic int unsigned char_bits(input int unsigned data_min,
                                             input int unsigned sel,
                                             input bit          par);
      return 1 + data_min + sel + (par ? 1 : 0);
   endfunction

endpackage

// File: rtl/thre_occ_track.sv
module thre_occ_track #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned LVL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_empty,
   input  logic [LVL_W-1:0] fifo_level,
   output logic             empty_rise,
   output logic             seen_two
);

   logic empty_q;

   // Reset to 0 so that the empty FIFO after reset counts as an empty event.
   always_ff @(posedge clk) begin
      if (!rst_n) empty_q <= 1'b0;
      else        empty_q <= fifo_empty;
   end

   assign empty_rise = fifo_empty & ~empty_q;

   generate
      if (DEPTH >= 2) begin : g_track
         logic seen_q;
         always_ff @(posedge clk) begin
            if (!rst_n) seen_q <= 1'b0;
            else        seen_q <= (fifo_level >= LVL_W'(2)) | (seen_q & ~empty_rise);
         end
         assign seen_two = seen_q;

         p_seen_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (fifo_level >= LVL_W'(2)) |=> seen_two);
         p_seen_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_two && !empty_rise) |=> seen_two);
      end else begin : g_single
         // A one-entry FIFO can never hold two characters.
         assign seen_two = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/thre_char_timer.sv
module thre_char_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] load_val,
   input  logic             cancel,
   input  logic             tick,
   output logic             expire,
   output logic             running
);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             last_tick;

   assign last_tick = run_q & ~start & ~cancel & tick & (cnt_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         run_q <= 1'b1;
         cnt_q <= load_val;
      end else if (run_q) begin
         if (cancel || last_tick) run_q <= 1'b0;
         else if (tick)           cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expire  = last_tick;
   assign running = run_q;

   p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !start && !tick && !cancel) |=> ($stable(cnt_q) && run_q));
   p_cancel_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && cancel && !start) |=> !run_q);

endmodule

// File: rtl/uart_txe_irq.sv
module uart_txe_irq #(
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned DATA_MIN   = 5,
   parameter int unsigned SEL_W      = 2,
   parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_empty,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic             thr_wr,
   input  logic             iir_rd,
   input  logic             thre_top,
   input  logic             baud_tick,
   input  logic [SEL_W-1:0] word_sel,
   input  logic             parity_en,
   output logic             thre_pend
);

   import thre_pkg::*;

   localparam int unsigned MAX_BITS = char_bits(DATA_MIN, (2 ** SEL_W) - 1, 1'b1);
   localparam int unsigned CNT_W    = $clog2(MAX_BITS + 1);

   generate
      if (FIFO_DEPTH < 1) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 1");
      end
      if (DATA_MIN < 1) begin : g_bad_min
         $error("DATA_MIN must be at least 1");
      end
      if (SEL_W < 1) begin : g_bad_sel
         $error("SEL_W must be at least 1");
      end
      if (LVL_W < $clog2(FIFO_DEPTH + 1)) begin : g_bad_lvl
         $error("LVL_W too narrow for FIFO_DEPTH");
      end
   endgenerate

   logic             empty_rise;
   logic             seen_two;
   logic             t_start;
   logic             t_cancel;
   logic             t_expire;
   logic             t_running;
   logic             clr;
   logic             set_now;
   logic [CNT_W-1:0] load_val;
   logic             pend_q;

   thre_occ_track #(
      .DEPTH (FIFO_DEPTH),
      .LVL_W (LVL_W)
   ) i_occ (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_empty (fifo_empty),
      .fifo_level (fifo_level),
      .empty_rise (empty_rise),
      .seen_two   (seen_two)
   );

   assign load_val = CNT_W'(char_bits(DATA_MIN, int'(word_sel), parity_en));
   assign t_start  = empty_rise & ~seen_two;
   assign t_cancel = thr_wr | ~fifo_empty;

   thre_char_timer #(
      .CNT_W (CNT_W)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (t_start),
      .load_val (load_val),
      .cancel   (t_cancel),
      .tick     (baud_tick),
      .expire   (t_expire),
      .running  (t_running)
   );

   assign clr     = thr_wr | (iir_rd & thre_top) | ~fifo_empty;
   assign set_now = (empty_rise & seen_two) | t_expire;

   always_ff @(posedge clk) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (clr)     pend_q <= 1'b0;
      else if (set_now) pend_q <= 1'b1;
   end

   assign thre_pend = pend_q;

   p_only_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_empty |=> !thre_pend);
   p_prompt_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_rise && seen_two && !clr) |=> thre_pend);
   p_held_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_rise && !seen_two) |=> !thre_pend);
   p_quiet_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
      t_running |-> !thre_pend);
   p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |=> !thre_pend);
   p_iir_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd && thre_top) |=> !thre_pend);
   p_iir_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (thre_pend && iir_rd && !thre_top && !thr_wr && fifo_empty) |=> thre_pend);

endmodule

// File: tb/test_uart_txe_irq.sv
module test_uart_txe_irq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       thr_wr = 1'b0;
   logic       pop = 1'b0;
   logic       iir_rd = 1'b0;
   logic       thre_top = 1'b0;
   logic       baud_tick = 1'b0;
   logic [1:0] word_sel = 2'd3;
   logic       parity_en = 1'b1;
   logic [4:0] lvl;
   logic       fifo_empty;
   logic       thre_pend;

   int    n_tests = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   assign fifo_empty = (lvl == 5'd0);

   // Stand-in FIFO occupancy: writes add a character, pops remove one.
   always @(posedge clk) begin
      if (!rst_n) lvl <= 5'd0;
      else        lvl <= lvl + 5'(thr_wr) - 5'(pop);
   end

   uart_txe_irq i_uart_txe_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_empty (fifo_empty),
      .fifo_level (lvl),
      .thr_wr     (thr_wr),
      .iir_rd     (iir_rd),
      .thre_top   (thre_top),
      .baud_tick  (baud_tick),
      .word_sel   (word_sel),
      .parity_en  (parity_en),
      .thre_pend  (thre_pend)
   );

   // Behavioural reference of the request.
   bit m_pend, m_run, m_seen, m_prev_empty;
   int m_left;
   always @(posedge clk) begin
      bit ev, fire, wipe;
      if (!rst_n) begin
         m_pend = 0; m_run = 0; m_seen = 0; m_prev_empty = 0; m_left = 0;
      end else begin
         ev   = fifo_empty && !m_prev_empty;
         fire = 0;
         wipe = thr_wr || (iir_rd && thre_top) || !fifo_empty;
         if (ev) begin
            if (m_seen) fire = 1;
            else begin
               m_run  = 1;
               m_left = 1 + 5 + int'(word_sel) + int'(parity_en);
            end
            m_seen = 0;
         end else if (m_run) begin
            if (thr_wr || !fifo_empty) m_run = 0;
            else if (baud_tick) begin
               if (m_left == 1) begin fire = 1; m_run = 0; end
               else m_left = m_left - 1;
            end
         end
         if (lvl >= 5'd2) m_seen = 1;
         if (wipe)      m_pend = 0;
         else if (fire) m_pend = 1;
         m_prev_empty = fifo_empty;
      end
   end

   task automatic check(input string req, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: thre_pend=%0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) check(cur_req, thre_pend, m_pend);
   end

   task automatic step(input logic w, input logic p, input logic r,
                       input logic t, input logic k);
      @(negedge clk);
      thr_wr = w; pop = p; iir_rd = r; thre_top = t; baud_tick = k;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         step(0, 0, 0, 0, 0);
         step(0, 0, 0, 0, 0);
         step(0, 0, 0, 0, 1);
      end
      step(0, 0, 0, 0, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
   end

   initial begin
      // R1: reset state
      cur_req = "R1";
      idle(3);
      check("R1", thre_pend, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(1);
      check("R1", thre_pend, 1'b0);

      // R4 / R5: start-up hold-back, 8 data bits plus parity gives 10 ticks
      cur_req = "R4";
      ticks(9);
      check("R4", thre_pend, 1'b0);
      cur_req = "R5";
      ticks(1);
      check("R5", thre_pend, 1'b1);

      // R8: read while not the top source leaves the request
      cur_req = "R8";
      step(0, 0, 1, 0, 0);
      idle(1);
      check("R8", thre_pend, 1'b1);

      // R7: read while the top source clears it, with no refire
      cur_req = "R7";
      step(0, 0, 1, 1, 0);
      idle(1);
      check("R7", thre_pend, 1'b0);
      ticks(12);
      check("R7", thre_pend, 1'b0);

      // R11 / R3: occupancy reaches 2, drops to 1 for a while, then drains
      word_sel  = 2'd0;
      parity_en = 1'b0;
      cur_req = "R11";
      step(1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      step(0, 1, 0, 0, 0);
      idle(3);
      check("R2", thre_pend, 1'b0);
      step(0, 1, 0, 0, 0);
      idle(2);
      check("R3", thre_pend, 1'b1);

      // R6: a write clears the request
      cur_req = "R6";
      step(1, 0, 0, 0, 0);
      idle(1);
      check("R6", thre_pend, 1'b0);

      // R10: single-character fill after an event is delayed (6 ticks)
      cur_req = "R10";
      step(0, 1, 0, 0, 0);
      ticks(5);
      check("R10", thre_pend, 1'b0);
      cur_req = "R5";
      ticks(1);
      check("R5", thre_pend, 1'b1);

      // R9: write during the delay cancels it (7 bits + parity = 9 ticks)
      word_sel  = 2'd2;
      parity_en = 1'b1;
      cur_req = "R9";
      step(1, 0, 0, 0, 0);
      step(0, 1, 0, 0, 0);
      ticks(3);
      step(1, 0, 0, 0, 0);
      ticks(12);
      check("R9", thre_pend, 1'b0);
      check("R2", fifo_empty, 1'b0);

      // R5: the next drain starts a fresh 9-tick delay
      cur_req = "R5";
      step(0, 1, 0, 0, 0);
      ticks(8);
      check("R4", thre_pend, 1'b0);
      ticks(1);
      check("R5", thre_pend, 1'b1);

      // R3 with a clearing write in the firing cycle: the write wins
      cur_req = "R3";
      step(1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      step(0, 1, 0, 0, 0);
      step(0, 1, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      idle(1);
      check("R6", thre_pend, 1'b0);

      idle(2);
      finish_run();
   end

endmodule